// File: doc/BRIEF.md
# Serial Flash Write-Enable Latch Controller

This block is the command front end of a serial flash device. It watches the four-wire serial slave interface (active-low chip select, serial clock, data in, data out) and holds the write-enable latch, the guard bit that every modifying operation needs. Two latch-only instructions set or clear the latch. Four write-class instructions (page write, page program, page erase, sector erase) are let through to the array sequencer only while the latch is set. The latch clears at reset and again whenever the sequencer reports that a write or erase has finished.

The serial pins are oversampled in the core clock domain through a synchronizer, so the core clock must run several times faster than the serial clock. An accepted write-class instruction produces a one-cycle start pulse that carries its opcode to the logic that runs the address, data and timing phases. That logic lies outside this block. The completion pulse comes back from that logic.

Top module: `spi_wel_ctrl`

## Requirements
- R1: After reset the latch output `wel_o` is 0, `start_vld_o` is 0 and `sdo_oe_o` is 0.
- R2: A frame that carries opcode 0x06 and whose chip select rises after exactly 8 serial clock rising edges sets `wel_o` to 1.
- R3: A frame that carries opcode 0x04 and whose chip select rises after exactly 8 serial clock rising edges clears `wel_o` to 0.
- R4: Data-in is sampled on each rising edge of the serial clock, most significant bit first. A 0x06 or 0x04 frame whose chip select rises after any count other than 8 leaves `wel_o` unchanged.
- R5: Opcodes 0x0A, 0x02, 0xDB and 0xD8 are write-class. When `wel_o` is 1 and the eighth bit of such an opcode arrives, `start_vld_o` pulses for exactly one cycle and `start_op_o` carries the opcode.
- R6: A write-class opcode that arrives while `wel_o` is 0 raises no start pulse and leaves `wel_o` at 0.
- R7: Any opcode other than the six named above raises no start pulse and leaves `wel_o` unchanged.
- R8: `wel_o` is 0 in the cycle after `op_done_i` is seen high. When completion and an accepted 0x06 frame end coincide, completion wins and the latch stays 0.
- R9: `sdo_oe_o` stays 0 at all times, so data-out is high-impedance during every instruction this block handles.
- R10: An accepted write-class instruction does not itself clear `wel_o`. The latch stays 1 until completion or a 0x04 frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, which oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| op_done_i | input | 1 | Completion pulse from the write/erase sequencer |
| sdo_oe_o | output | 1 | Data-out drive enable (0 = high-impedance) |
| wel_o | output | 1 | Write-enable latch state |
| start_vld_o | output | 1 | One-cycle start pulse for an accepted write-class instruction |
| start_op_o | output | 8 | Opcode of the accepted instruction, valid with start_vld_o |

## Verification
The bench builds the block with the default two-stage synchronizer and a serial clock half-period of three core cycles. That ratio keeps a full 8-bit frame under about seventy cycles. At that cost all 256 opcodes can be swept twice, once with the latch preset to 0 and once preset to 1, so every gated, latch-changing and ignored code is checked against an arithmetic model. Short frames and long frames of 0 to 12 clocks exercise the exact-count rule in both directions. A completion level held across the end of a 0x06 frame exercises the priority rule.

// File: rtl/wel_pkg.sv
package wel_pkg;
    localparam int OP_W = 8;
    typedef logic [OP_W-1:0] op_t;

    localparam op_t OP_LATCH_SET  = 8'h06;
    localparam op_t OP_LATCH_CLR  = 8'h04;
    localparam op_t OP_PAGE_WRITE = 8'h0A;
    localparam op_t OP_PAGE_PROG  = 8'h02;
    localparam op_t OP_PAGE_ERASE = 8'hDB;
    localparam op_t OP_SECT_ERASE = 8'hD8;

    function automatic logic is_guarded(op_t op);
        return (op == OP_PAGE_WRITE) || (op == OP_PAGE_PROG) ||
               (op == OP_PAGE_ERASE) || (op == OP_SECT_ERASE);
    endfunction
endpackage

// File: rtl/wel_in_sync.sv
module wel_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    output logic cs_n_o,
    output logic mosi_o,
    output logic sck_rise_o,
    output logic cs_rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] cs_sh;
        logic [STAGES-1:0] sck_sh;
        logic [STAGES-1:0] mosi_sh;
        logic              cs_last;
        logic              sck_last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.cs_sh    = {s_q.cs_sh[STAGES-2:0], cs_n_i};
        s_d.sck_sh   = {s_q.sck_sh[STAGES-2:0], sck_i};
        s_d.mosi_sh  = {s_q.mosi_sh[STAGES-2:0], mosi_i};
        s_d.cs_last  = s_q.cs_sh[STAGES-1];
        s_d.sck_last = s_q.sck_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cs_sh    <= '1;
            s_q.sck_sh   <= '0;
            s_q.mosi_sh  <= '0;
            s_q.cs_last  <= 1'b1;
            s_q.sck_last <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cs_n_o     = s_q.cs_sh[STAGES-1];
    assign mosi_o     = s_q.mosi_sh[STAGES-1];
    assign sck_rise_o = s_q.sck_sh[STAGES-1] & ~s_q.sck_last;
    assign cs_rise_o  = s_q.cs_sh[STAGES-1] & ~s_q.cs_last;
endmodule

// File: rtl/wel_frame.sv
module wel_frame
    import wel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic mosi_s,
    input  logic sck_rise,
    input  logic cs_rise,
    output logic byte_done_o,
    output logic exact_end_o,
    output op_t  op_o
);
    localparam int CW = $clog2(OP_W + 2);
    localparam logic [CW-1:0] CNT_FULL  = CW'(OP_W);
    localparam logic [CW-1:0] CNT_LIMIT = CW'(OP_W + 1);
    localparam logic [CW-1:0] CNT_LAST  = CW'(OP_W - 1);

    typedef struct packed {
        op_t           shreg;
        logic [CW-1:0] cnt;
        logic          byte_done;
        logic          exact_end;
    } frame_t;

    frame_t f_d, f_q;

    always_comb begin
        f_d           = f_q;
        f_d.byte_done = 1'b0;
        f_d.exact_end = 1'b0;
        if (cs_n_s) begin
            f_d.cnt = '0;
            if (cs_rise && (f_q.cnt == CNT_FULL)) begin
                f_d.exact_end = 1'b1;
            end
        end else if (sck_rise) begin
            if (f_q.cnt < CNT_FULL) begin
                f_d.shreg = {f_q.shreg[OP_W-2:0], mosi_s};
            end
            if (f_q.cnt != CNT_LIMIT) begin
                f_d.cnt = f_q.cnt + 1'b1;
            end
            if (f_q.cnt == CNT_LAST) begin
                f_d.byte_done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign byte_done_o = f_q.byte_done;
    assign exact_end_o = f_q.exact_end;
    assign op_o        = f_q.shreg;
endmodule

// File: rtl/wel_latch.sv
module wel_latch
    import wel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic byte_done,
    input  logic exact_end,
    input  op_t  op,
    input  logic done_i,
    output logic wel_o,
    output logic start_vld_o,
    output op_t  start_op_o
);
    typedef struct packed {
        logic wel;
        logic start_vld;
        op_t  start_op;
    } latch_t;

    latch_t l_d, l_q;
    logic   accept;

    always_comb begin
        l_d    = l_q;
        accept = byte_done && is_guarded(op) && l_q.wel;
        l_d.start_vld = accept;
        if (accept) begin
            l_d.start_op = op;
        end
        if (done_i) begin
            l_d.wel = 1'b0;
        end else if (exact_end && (op == OP_LATCH_SET)) begin
            l_d.wel = 1'b1;
        end else if (exact_end && (op == OP_LATCH_CLR)) begin
            l_d.wel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign wel_o       = l_q.wel;
    assign start_vld_o = l_q.start_vld;
    assign start_op_o  = l_q.start_op;
endmodule

// File: rtl/spi_wel_ctrl.sv
module spi_wel_ctrl
    import wel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic       op_done_i,
    output logic       sdo_oe_o,
    output logic       wel_o,
    output logic       start_vld_o,
    output logic [7:0] start_op_o
);
    logic cs_n_s, mosi_s, sck_rise, cs_rise;
    logic byte_done, exact_end;
    op_t  op;

    wel_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n),
        .sck_i      (sck),
        .mosi_i     (mosi),
        .cs_n_o     (cs_n_s),
        .mosi_o     (mosi_s),
        .sck_rise_o (sck_rise),
        .cs_rise_o  (cs_rise)
    );

    wel_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_s      (cs_n_s),
        .mosi_s      (mosi_s),
        .sck_rise    (sck_rise),
        .cs_rise     (cs_rise),
        .byte_done_o (byte_done),
        .exact_end_o (exact_end),
        .op_o        (op)
    );

    wel_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_done   (byte_done),
        .exact_end   (exact_end),
        .op          (op),
        .done_i      (op_done_i),
        .wel_o       (wel_o),
        .start_vld_o (start_vld_o),
        .start_op_o  (start_op_o)
    );

    // No read instruction is handled here, so data-out is never driven.
    assign sdo_oe_o = 1'b0;
endmodule

// File: rtl/spi_wel_ctrl_chk.sv
module spi_wel_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_done_i,
    input logic       wel_o,
    input logic       start_vld_o,
    input logic [7:0] start_op_o
);
    // R8
    done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done_i |=> !wel_o);

    // R8
    rise_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_o) |-> !$past(op_done_i));

    // R5
    start_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_vld_o |-> $past(wel_o));

    // R5
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_vld_o |=> !start_vld_o);

    // R5
    start_op_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_vld_o |-> (start_op_o == 8'h0A || start_op_o == 8'h02 ||
                         start_op_o == 8'hDB || start_op_o == 8'hD8));
endmodule

bind spi_wel_ctrl spi_wel_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_done_i   (op_done_i),
    .wel_o       (wel_o),
    .start_vld_o (start_vld_o),
    .start_op_o  (start_op_o)
);

// File: tb/spi_wel_ctrl_bench.sv
`timescale 1ns/1ps
module spi_wel_ctrl_bench;
    localparam int HALF = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       op_done = 1'b0;
    logic       sdo_oe, wel, start_vld;
    logic [7:0] start_op;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    logic [7:0] last_op = 8'h00;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    spi_wel_ctrl u_spi_wel_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sck         (sck),
        .mosi        (mosi),
        .op_done_i   (op_done),
        .sdo_oe_o    (sdo_oe),
        .wel_o       (wel),
        .start_vld_o (start_vld),
        .start_op_o  (start_op)
    );

    always @(negedge clk) begin
        if (rst_n && start_vld) begin
            starts  <= starts + 1;
            last_op <= start_op;
        end
        if (rst_n && sdo_oe) begin
            errors <= errors + 1;
            $display("FAIL R9 data-out enabled: actual %0d expected 0", sdo_oe);
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic guarded(input logic [7:0] op);
        case (op)
            8'h0A, 8'h02, 8'hDB, 8'hD8: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Sends the first nbits of the 16-bit word, MSB first, then raises chip select.
    task automatic frame(input logic [15:0] word, input int nbits);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = word[15-i];
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_op(input logic [7:0] op);
        frame({op, 8'h00}, 8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(wel == 1'b0, "R1 wel after reset", int'(wel), 0);
        chk(start_vld == 1'b0, "R1 start after reset", int'(start_vld), 0);
        chk(sdo_oe == 1'b0, "R1 R9 oe after reset", int'(sdo_oe), 0);

        // R2 / R3 basic
        send_op(8'h06);
        chk(wel == 1'b1, "R2 set", int'(wel), 1);
        send_op(8'h04);
        chk(wel == 1'b0, "R3 clear", int'(wel), 0);

        // R4 wrong bit counts, from both latch states
        for (int n = 0; n <= 12; n++) begin
            if (n != 8) begin
                send_op(8'h04);
                frame({8'h06, 8'h00}, n);
                chk(wel == 1'b0, "R4 short/long set frame", int'(wel), 0);
                send_op(8'h06);
                frame({8'h04, 8'h00}, n);
                chk(wel == 1'b1, "R4 short/long clear frame", int'(wel), 1);
            end
        end

        // R5 R6 R7 R2 R3 R10 exhaustive opcode sweep against both latch states
        for (int op = 0; op < 256; op++) begin
            for (int pre = 0; pre < 2; pre++) begin
                logic [7:0] o;
                logic exp_wel;
                int exp_starts;
                o = 8'(op);
                send_op(pre == 1 ? 8'h06 : 8'h04);
                starts = 0;
                send_op(o);
                if (o == 8'h06) exp_wel = 1'b1;
                else if (o == 8'h04) exp_wel = 1'b0;
                else exp_wel = (pre == 1);
                exp_starts = (guarded(o) && pre == 1) ? 1 : 0;
                chk(wel == exp_wel, "R2 R3 R6 R7 R10 latch after opcode", int'(wel), int'(exp_wel));
                chk(starts == exp_starts, "R5 R6 R7 start count", starts, exp_starts);
                if (exp_starts == 1)
                    chk(last_op == o, "R5 start opcode", int'(last_op), int'(o));
            end
        end

        // R5 write-class with trailing address bits still starts once
        send_op(8'h06);
        starts = 0;
        frame({8'hD8, 8'h5A}, 16);
        chk(starts == 1, "R5 long write-class frame", starts, 1);
        chk(wel == 1'b1, "R10 latch kept after start", int'(wel), 1);

        // R8 completion clears
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
        @(negedge clk);
        chk(wel == 1'b0, "R8 completion clears", int'(wel), 0);

        // R8 completion beats a coinciding set frame
        op_done = 1'b1;
        send_op(8'h06);
        op_done = 1'b0;
        @(negedge clk);
        chk(wel == 1'b0, "R8 completion priority", int'(wel), 0);

        // R6 after completion, write-class is rejected again
        starts = 0;
        send_op(8'h02);
        chk(starts == 0, "R6 rejected after completion", starts, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule